// File: doc/BRIEF.md
# Paged Effective Address Unit

This unit turns a memory-reference instruction of a 12-bit, single-accumulator machine into a 15-bit physical operand address. Memory is split into 8 fields of 4096 words, and each field holds 32 pages of 128 words. The unit takes an instruction word together with the address it was fetched from, plus the current instruction field and data field. It decodes the opcode and the addressing flags and forms a direct address, either in page zero or in the page of the instruction. For an indirect reference it reads a pointer word over a synchronous memory port. When the pointer sits in the auto-index window of page zero, it increments the pointer and writes it back before using it.

A request is accepted with a valid/ready handshake while the unit is idle. The result is then held on the executor side until the executor takes it. Opcodes 6 and 7 carry no memory operand. The unit flags them as bypassed and makes no memory access for them. Bit numbering in this text follows the machine's convention: bit 0 is the most significant bit of a word, which is vector bit 11 on the ports.

Top module: `paged_ea_unit`

## Requirements
- R1: The instruction word is split as follows. Opcode is req_instr[11:9] (machine bits 0-2). Indirect flag is req_instr[8] (bit 3). Page-select flag is req_instr[7] (bit 4). Offset is req_instr[6:0] (bits 5-11). ea_op returns the opcode of the accepted instruction.
- R2: With the indirect flag 0 and the page-select flag 0, ea_addr is {req_ifield, 5'b0, offset}. ea_valid rises one clock after acceptance, and no memory access is made.
- R3: With the page-select flag 1, the 12-bit location is {req_pc[11:7], offset}. For a direct reference it is prefixed with req_ifield.
- R4: Opcodes 6 and 7 are bypassed whatever the flags. The result has ea_bypass=1 and ea_addr=0, ea_valid rises one clock after acceptance, and the memory enables stay low.
- R5: An indirect reference outside the auto-index window makes exactly one read, at {req_ifield, location}. The result is {req_dfield, pointer}, with ea_valid two clocks after acceptance and no write.
- R6: An indirect reference whose 12-bit location is 0010 to 0017 octal reads the pointer and writes pointer+1 back to the same physical location. The result is {req_dfield, pointer+1}, with ea_valid three clocks after acceptance. A read and a write never occur in the same cycle. A direct reference to the window writes nothing.
- R7: The pointer increment wraps from 7777 to 0000 octal and never changes the field bits of the result.
- R8: req_ready is high only while idle. While ea_valid is high and ea_ready is low, ea_addr, ea_op and ea_bypass stay stable, and new requests are refused.
- R9: After reset, req_ready is 1, ea_valid is 0, and both memory enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Instruction offered |
| req_ready | output | 1 | Unit idle, request accepted this cycle if valid |
| req_instr | input | 12 | Instruction word |
| req_pc | input | 12 | Address the instruction was fetched from |
| req_ifield | input | 3 | Instruction field |
| req_dfield | input | 3 | Data field |
| mem_rd_en | output | 1 | Read strobe; data returns on mem_rdata next cycle |
| mem_wr_en | output | 1 | Write strobe for pointer write-back |
| mem_addr | output | 15 | Physical memory address |
| mem_wdata | output | 12 | Incremented pointer |
| mem_rdata | input | 12 | Read data, one cycle after mem_rd_en |
| ea_valid | output | 1 | Effective address available |
| ea_ready | input | 1 | Executor takes the result |
| ea_addr | output | 15 | Physical effective address |
| ea_op | output | 3 | Opcode of the instruction |
| ea_bypass | output | 1 | Opcode carries no memory operand |

## Verification
In the write-back step two functions share one cycle: the incremented pointer goes to memory, and the same incremented value, prefixed with the data field, becomes the result. The wrap case provokes this with a pointer of 7777 octal under data field 7. The bench judges the written memory word and the presented address separately, and expects zero in the low twelve bits with the field bits intact. It also counts read and write strobes per transaction. A further case has a page-select flag of 1 on an instruction in page zero, which must still reach the auto-index window.

// File: rtl/paged_ea_pkg.sv
package paged_ea_pkg;
  localparam int WORD_W        = 12;
  localparam int FIELD_W       = 3;
  localparam int OP_W          = 3;
  localparam int OFF_W         = 7;
  localparam int PAGE_W        = WORD_W - OFF_W;
  localparam int PADDR_W       = FIELD_W + WORD_W;
  localparam int AUTO_LO       = 8;
  localparam int AUTO_HI       = 15;
  localparam int BYPASS_OP_MIN = 6;

  localparam logic [WORD_W-1:0] PAGE_MASK = {{PAGE_W{1'b1}}, {OFF_W{1'b0}}};

  typedef enum logic [1:0] {
    ST_FETCH   = 2'd0,
    ST_DEFER   = 2'd1,
    ST_AUTOINC = 2'd2,
    ST_DONE    = 2'd3
  } ea_state_e;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic             ind;
    logic             cur_page;
    logic [OFF_W-1:0] off;
  } mri_t;

  function automatic logic [WORD_W-1:0] form_direct(
      input logic [WORD_W-1:0] pc, input logic cur, input logic [OFF_W-1:0] off);
    logic [WORD_W-1:0] base;
    base = cur ? (pc & PAGE_MASK) : '0;
    return base | {{PAGE_W{1'b0}}, off};
  endfunction

  function automatic logic in_auto_window(input logic [WORD_W-1:0] loc);
    return (loc >= WORD_W'(AUTO_LO)) && (loc <= WORD_W'(AUTO_HI));
  endfunction

  function automatic logic [WORD_W-1:0] bump_ptr(input logic [WORD_W-1:0] p);
    return p + {{(WORD_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic is_bypass(input logic [OP_W-1:0] op);
    return op >= OP_W'(BYPASS_OP_MIN);
  endfunction
endpackage

// File: rtl/ea_decode.sv
module ea_decode
  import paged_ea_pkg::*;
(
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] pc,
  output logic [OP_W-1:0]   op,
  output logic              indirect,
  output logic              bypass,
  output logic              autoidx,
  output logic [WORD_W-1:0] dir_loc
);
  mri_t w;

  always_comb begin
    w        = mri_t'(instr);
    op       = w.op;
    indirect = w.ind;
    bypass   = is_bypass(w.op);
    dir_loc  = form_direct(pc, w.cur_page, w.off);
    autoidx  = w.ind && in_auto_window(dir_loc);
  end
endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import paged_ea_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [OP_W-1:0]    dec_op,
  input  logic               dec_ind,
  input  logic               dec_bypass,
  input  logic               dec_auto,
  input  logic [WORD_W-1:0]  dec_loc,
  input  logic [FIELD_W-1:0] ifield,
  input  logic [FIELD_W-1:0] dfield,
  output logic               mem_rd_en,
  output logic               mem_wr_en,
  output logic [PADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0]  mem_wdata,
  input  logic [WORD_W-1:0]  mem_rdata,
  output logic               ea_valid,
  input  logic               ea_ready,
  output logic [PADDR_W-1:0] ea_addr,
  output logic [OP_W-1:0]    ea_op,
  output logic               ea_bypass
);
  ea_state_e          state_q;
  logic [FIELD_W-1:0] if_q, df_q;
  logic [WORD_W-1:0]  loc_q, ptr_q;
  logic               auto_q, byp_q;
  logic [OP_W-1:0]    op_q;
  logic [PADDR_W-1:0] res_q;

  // named internal events
  logic accept, start_defer, wb_fire, retire;
  assign accept      = req_valid && (state_q == ST_FETCH);
  assign start_defer = accept && dec_ind && !dec_bypass;
  assign wb_fire     = (state_q == ST_AUTOINC);
  assign retire      = (state_q == ST_DONE) && ea_ready;

  assign req_ready = (state_q == ST_FETCH);
  assign mem_rd_en = start_defer;
  assign mem_wr_en = wb_fire;
  assign mem_addr  = wb_fire ? {if_q, loc_q} : {ifield, dec_loc};
  assign mem_wdata = bump_ptr(ptr_q);
  assign ea_valid  = (state_q == ST_DONE);
  assign ea_addr   = res_q;
  assign ea_op     = op_q;
  assign ea_bypass = byp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      if_q    <= '0;
      df_q    <= '0;
      loc_q   <= '0;
      ptr_q   <= '0;
      auto_q  <= 1'b0;
      byp_q   <= 1'b0;
      op_q    <= '0;
      res_q   <= '0;
    end else begin
      case (state_q)
        ST_FETCH: if (accept) begin
          op_q   <= dec_op;
          byp_q  <= dec_bypass;
          if_q   <= ifield;
          df_q   <= dfield;
          loc_q  <= dec_loc;
          auto_q <= dec_auto;
          if (dec_bypass) begin
            res_q   <= '0;
            state_q <= ST_DONE;
          end else if (dec_ind) begin
            state_q <= ST_DEFER;
          end else begin
            res_q   <= {ifield, dec_loc};
            state_q <= ST_DONE;
          end
        end
        ST_DEFER: begin
          ptr_q <= mem_rdata;
          if (auto_q) begin
            state_q <= ST_AUTOINC;
          end else begin
            res_q   <= {df_q, mem_rdata};
            state_q <= ST_DONE;
          end
        end
        ST_AUTOINC: begin
          res_q   <= {df_q, bump_ptr(ptr_q)};
          state_q <= ST_DONE;
        end
        ST_DONE: if (retire) state_q <= ST_FETCH;
        default: state_q <= ST_FETCH;
      endcase
    end
  end

  // R8
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && !ea_ready) |=> (ea_valid && $stable(ea_addr) && $stable(ea_op) && $stable(ea_bypass)));

  // R6
  wb_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> (ea_valid && (ea_addr[WORD_W-1:0] == $past(mem_wdata))));

  // R5
  rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> (!req_ready && !mem_rd_en && !ea_valid));

  // R6
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd_en, mem_wr_en}));

  // R8
  busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ea_valid |-> !req_ready);
endmodule

// File: rtl/paged_ea_unit.sv
module paged_ea_unit
  import paged_ea_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [WORD_W-1:0]  req_instr,
  input  logic [WORD_W-1:0]  req_pc,
  input  logic [FIELD_W-1:0] req_ifield,
  input  logic [FIELD_W-1:0] req_dfield,
  output logic               mem_rd_en,
  output logic               mem_wr_en,
  output logic [PADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0]  mem_wdata,
  input  logic [WORD_W-1:0]  mem_rdata,
  output logic               ea_valid,
  input  logic               ea_ready,
  output logic [PADDR_W-1:0] ea_addr,
  output logic [OP_W-1:0]    ea_op,
  output logic               ea_bypass
);
  logic [OP_W-1:0]   d_op;
  logic              d_ind, d_byp, d_auto;
  logic [WORD_W-1:0] d_loc;

  ea_decode u_dec (
    .instr(req_instr), .pc(req_pc),
    .op(d_op), .indirect(d_ind), .bypass(d_byp), .autoidx(d_auto), .dir_loc(d_loc)
  );

  ea_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .dec_op(d_op), .dec_ind(d_ind), .dec_bypass(d_byp), .dec_auto(d_auto), .dec_loc(d_loc),
    .ifield(req_ifield), .dfield(req_dfield),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .ea_valid(ea_valid), .ea_ready(ea_ready), .ea_addr(ea_addr),
    .ea_op(ea_op), .ea_bypass(ea_bypass)
  );
endmodule

// File: tb/sim_paged_ea_unit.sv
module sim_paged_ea_unit;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_ready;
  logic [11:0] req_instr = 0, req_pc = 0;
  logic [2:0]  req_ifield = 0, req_dfield = 0;
  logic        mem_rd_en, mem_wr_en;
  logic [14:0] mem_addr;
  logic [11:0] mem_wdata, mem_rdata;
  logic        ea_valid, ea_ready = 1;
  logic [14:0] ea_addr;
  logic [2:0]  ea_op;
  logic        ea_bypass;

  paged_ea_unit u0 (.*);

  always #4 clk = ~clk;

  typedef struct {
    logic [14:0] addr;
    logic [2:0]  op;
    logic        byp;
    int          lat;
    int          acc;
    string       tag;
  } exp_t;
  exp_t sb[$];

  int checks = 0, errors = 0, cyc = 0, rd_cnt = 0, wr_cnt = 0;
  logic [11:0] mem [0:1023];

  function automatic int midx(input logic [14:0] a);
    return int'({a[14:12], a[6:0]});
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rd_en) begin mem_rdata <= mem[midx(mem_addr)]; rd_cnt <= rd_cnt + 1; end
    if (mem_wr_en) begin mem[midx(mem_addr)] <= mem_wdata; wr_cnt <= wr_cnt + 1; end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0o expected=%0o", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard items as results are taken
  always @(negedge clk) begin
    if (rst_n && ea_valid && ea_ready) begin
      if (sb.size() == 0) chk(1'b0, "R8 unexpected result", 32'(ea_addr), 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk(ea_addr == e.addr, {e.tag, " addr"}, 32'(ea_addr), 32'(e.addr));
        chk(ea_op == e.op, {e.tag, " R1 opcode"}, 32'(ea_op), 32'(e.op));
        chk(ea_bypass == e.byp, {e.tag, " bypass flag"}, 32'(ea_bypass), 32'(e.byp));
        if (e.lat >= 0)
          chk(cyc - e.acc == e.lat, {e.tag, " latency"}, 32'(cyc - e.acc), 32'(e.lat));
      end
    end
  end

  // driver
  task automatic run(input logic [11:0] ins, input logic [11:0] pc, input logic [2:0] fi,
                     input logic [2:0] fd, input logic [14:0] xaddr, input logic xbyp,
                     input int lat, input int nrd, input int nwr, input string tag);
    exp_t e;
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0;
    chk(req_ready == 1'b1, {tag, " R8 ready when idle"}, 32'(req_ready), 1);
    req_valid = 1; req_instr = ins; req_pc = pc; req_ifield = fi; req_dfield = fd;
    e.addr = xaddr; e.op = ins[11:9]; e.byp = xbyp; e.lat = lat; e.acc = cyc; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    req_valid = 0;
    wait (sb.size() == 0);
    @(negedge clk);
    chk(rd_cnt == nrd, {tag, " read count"}, 32'(rd_cnt), 32'(nrd));
    chk(wr_cnt == nwr, {tag, " write count"}, 32'(wr_cnt), 32'(nwr));
  endtask

  task automatic mchk(input logic [14:0] a, input logic [11:0] v, input string tag);
    chk(mem[midx(a)] == v, tag, 32'(mem[midx(a)]), 32'(v));
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    mem_rdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk(req_ready == 1'b1, "R9 req_ready after reset", 32'(req_ready), 1);
    chk(ea_valid == 1'b0, "R9 ea_valid after reset", 32'(ea_valid), 0);
    chk(!mem_rd_en && !mem_wr_en, "R9 memory idle", 32'({mem_rd_en, mem_wr_en}), 0);
    rst_n = 1;

    // R2 page zero direct
    run({3'o1, 1'b0, 1'b0, 7'o45}, 12'o3456, 3'd2, 3'd5, {3'd2, 12'o0045}, 0, 1, 0, 0, "R2 direct page zero");
    // R3 current page direct
    run({3'o2, 1'b0, 1'b1, 7'o17}, 12'o3456, 3'd4, 3'd1, {3'd4, (12'o3456 & 12'o7600) | 12'o17}, 0, 1, 0, 0, "R3 direct current page");
    // R6 direct into window writes nothing
    run({3'o3, 1'b0, 1'b0, 7'o12}, 12'o0100, 3'd1, 3'd1, {3'd1, 12'o0012}, 0, 1, 0, 0, "R6 direct window no write");
    // R4 bypass opcodes
    run({3'o6, 1'b1, 1'b1, 7'o33}, 12'o1234, 3'd1, 3'd2, 15'd0, 1, 1, 0, 0, "R4 opcode 6 bypass");
    run({3'o7, 1'b0, 1'b0, 7'o00}, 12'o4000, 3'd5, 3'd6, 15'd0, 1, 1, 0, 0, "R4 opcode 7 bypass");
    // R5 indirect via page zero
    mem[midx({3'd1, 12'o0040})] = 12'o1234;
    run({3'o0, 1'b1, 1'b0, 7'o40}, 12'o2000, 3'd1, 3'd6, {3'd6, 12'o1234}, 0, 2, 1, 0, "R5 indirect page zero");
    mchk({3'd1, 12'o0040}, 12'o1234, "R5 pointer unchanged");
    // R5 R3 indirect via current page
    mem[midx({3'd1, 12'o2205})] = 12'o6543;
    run({3'o4, 1'b1, 1'b1, 7'o05}, 12'o2200, 3'd1, 3'd2, {3'd2, 12'o6543}, 0, 2, 1, 0, "R5 R3 indirect current page");
    // R6 auto-index lower edge
    mem[midx({3'd3, 12'o0010})] = 12'o0100;
    run({3'o5, 1'b1, 1'b0, 7'o10}, 12'o1000, 3'd3, 3'd4, {3'd4, 12'o0101}, 0, 3, 1, 1, "R6 auto 0010");
    mchk({3'd3, 12'o0010}, 12'o0101, "R6 write-back 0010");
    // R6 upper edge
    mem[midx({3'd3, 12'o0017})] = 12'o4444;
    run({3'o1, 1'b1, 1'b0, 7'o17}, 12'o1000, 3'd3, 3'd4, {3'd4, 12'o4445}, 0, 3, 1, 1, "R6 auto 0017");
    mchk({3'd3, 12'o0017}, 12'o4445, "R6 write-back 0017");
    // R6 just outside the window
    mem[midx({3'd3, 12'o0020})] = 12'o2222;
    run({3'o1, 1'b1, 1'b0, 7'o20}, 12'o1000, 3'd3, 3'd4, {3'd4, 12'o2222}, 0, 2, 1, 0, "R6 0020 not auto");
    mchk({3'd3, 12'o0020}, 12'o2222, "R6 0020 untouched");
    mem[midx({3'd3, 12'o0007})] = 12'o3333;
    run({3'o2, 1'b1, 1'b0, 7'o07}, 12'o1000, 3'd3, 3'd4, {3'd4, 12'o3333}, 0, 2, 1, 0, "R6 0007 not auto");
    mchk({3'd3, 12'o0007}, 12'o3333, "R6 0007 untouched");
    // R7 wrap without carry into field
    mem[midx({3'd0, 12'o0013})] = 12'o7777;
    run({3'o3, 1'b1, 1'b0, 7'o13}, 12'o5000, 3'd0, 3'd7, {3'd7, 12'o0000}, 0, 3, 1, 1, "R7 wrap");
    mchk({3'd0, 12'o0013}, 12'o0000, "R7 wrapped pointer");
    // R6 window reached with page-select 1 from page zero, twice
    mem[midx({3'd0, 12'o0014})] = 12'o0700;
    run({3'o2, 1'b1, 1'b1, 7'o14}, 12'o0050, 3'd0, 3'd3, {3'd3, 12'o0701}, 0, 3, 1, 1, "R6 R3 auto via current page");
    run({3'o2, 1'b1, 1'b1, 7'o14}, 12'o0050, 3'd0, 3'd3, {3'd3, 12'o0702}, 0, 3, 1, 1, "R6 repeated auto");
    mchk({3'd0, 12'o0014}, 12'o0702, "R6 pointer after two uses");

    // R8 stall: result held, new request refused
    begin
      exp_t e;
      logic [14:0] held;
      @(negedge clk);
      ea_ready = 0;
      req_valid = 1; req_instr = {3'o4, 1'b0, 1'b0, 7'o55}; req_pc = 12'o0; req_ifield = 3'd6; req_dfield = 3'd0;
      e.addr = {3'd6, 12'o0055}; e.op = 3'o4; e.byp = 0; e.lat = -1; e.acc = cyc; e.tag = "R8 stalled";
      sb.push_back(e);
      @(negedge clk);
      held = ea_addr;
      req_instr = {3'o0, 1'b0, 1'b0, 7'o11}; req_ifield = 3'd2;
      repeat (4) @(negedge clk);
      chk(ea_valid == 1'b1, "R8 valid held", 32'(ea_valid), 1);
      chk(ea_addr == held && held == {3'd6, 12'o0055}, "R8 addr stable", 32'(ea_addr), 32'({3'd6, 12'o0055}));
      chk(req_ready == 1'b0, "R8 refuse while busy", 32'(req_ready), 0);
      req_valid = 0;
      ea_ready = 1;
      wait (sb.size() == 0);
      @(negedge clk);
      chk(ea_valid == 1'b0 && req_ready == 1'b1, "R8 back to idle", 32'({ea_valid, req_ready}), 1);
    end

    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R8 no extra results", 32'(sb.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule